// File: doc/BRIEF.md
# Prescaled Modulo Timer Counter

This block is the shared time base of a multi-channel capture/compare timer. A 16-bit up-counter advances once per count enable. The enable comes either from one of seven power-of-two divisions of the bus clock or from rising edges on an external clock pin, which is first brought into the bus clock domain. The counter runs free, wrapping from all ones to zero. It can instead wrap after a programmable limit that software writes as two byte halves. Every wrap raises an overflow flag, which can request an interrupt.

Software reaches the block through a byte-wide register port. Reading the count never disturbs counting. A read of the upper count byte takes a snapshot of the lower byte, so the next lower-byte read returns the matching half of the same count value. The full count is also driven on a parallel output for the capture/compare channels.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count is zero, the overflow flag, interrupt enable and hold bit are clear, the select code is 0, the limit is 0x0000, and the interrupt output is low.
- R2: Select codes 0 to 6 (control bits 2:0) divide the bus clock by 1, 2, 4, 8, 16, 32 and 64. After a clear, the count equals floor(N / 2^code) once N counting clock edges have passed.
- R3: Select code 7 counts rising edges of the external clock pin. Each rising edge adds exactly one, on the third bus clock edge after the pin rises. A level held high adds nothing more.
- R4: With a non-zero limit, a count enable that arrives while the count equals the limit loads zero and sets the overflow flag (control bit 7).
- R5: A limit of 0x0000 selects free running. An enable at 0xFFFF loads zero and sets the overflow flag.
- R6: A read of the upper count byte (address 1) captures the lower byte. The next read of address 2 returns that captured byte, and a later address-2 read returns the live lower byte.
- R7: Reads of any register leave the count sequence unchanged.
- R8: While the hold bit (control bit 5) is set, neither the count nor the prescaler advances.
- R9: Writing a one to control bit 4 clears the count and the prescaler on that edge. The bit always reads back as zero.
- R10: The interrupt output is high exactly when the overflow flag and the interrupt enable (control bit 6) are both set. Writing a one to control bit 7 clears the flag, and writing a zero there leaves it unchanged.
- R11: Writes to the count addresses (1 and 2) have no effect on the count.
- R12: The limit is written as an upper byte at address 3 and a lower byte at address 4, and both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers the snapshot side effects) |
| bus_addr | input | 3 | Register address: 0 control, 1 count upper, 2 count lower, 3 limit upper, 4 limit lower |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ext_clk | input | 1 | External count clock, asynchronous to clk |
| cnt_o | output | 16 | Live count to the channels |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A register write takes effect on the clock edge that samples the strobe. The next prescaled enable falls on the 2^code-th edge after a clear, so the bench predicts the count after N edges as floor(N / 2^code), reduced by the wrap rule. Read data is combinational and is sampled one time unit after the strobes are driven at the falling edge, before the edge that applies the snapshot. An external rising edge first shows on the count three rising edges later. The bench samples at falling edges exactly at these points and folds every edge consumed by a register access into its prediction.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned BUS_AW = 3;
   localparam int unsigned BUS_DW = 8;
   localparam int unsigned SEL_W  = 3;

   localparam logic [BUS_AW-1:0] A_CTRL = 3'd0;
   localparam logic [BUS_AW-1:0] A_CNTH = 3'd1;
   localparam logic [BUS_AW-1:0] A_CNTL = 3'd2;
   localparam logic [BUS_AW-1:0] A_LIMH = 3'd3;
   localparam logic [BUS_AW-1:0] A_LIML = 3'd4;

   localparam int unsigned B_FLAG = 7;
   localparam int unsigned B_IE   = 6;
   localparam int unsigned B_HOLD = 5;
   localparam int unsigned B_CLR  = 4;

   localparam logic [SEL_W-1:0] SEL_EXT = '1;

   typedef struct packed {
      logic             flag;
      logic             ie;
      logic             hold;
      logic [SEL_W-1:0] sel;
   } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int unsigned DIV_TAPS    = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             run,
   input  logic             clr,
   input  logic             ext_clk,
   output logic             tick
);
   localparam int unsigned PW    = (DIV_TAPS > 1) ? DIV_TAPS - 1 : 1;
   localparam int unsigned NCODE = 1 << SEL_W;

   logic [PW-1:0]        pre_q;
   logic [NCODE-1:0]     tap;
   logic [SYNC_STAGES:0] sync_q;
   logic                 ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= ext_clk;
   end

   for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   assign tap[0] = 1'b1;
   for (genvar k = 1; k < NCODE - 1; k++) begin : g_tap
      if (k < DIV_TAPS) begin : g_div
         assign tap[k] = &pre_q[k-1:0];
      end else begin : g_none
         assign tap[k] = 1'b0;
      end
   end
   assign tap[NCODE-1] = ext_rise;

   assign tick = run & ~clr & tap[sel];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] lim,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   logic at_lim;

   assign at_lim = ((lim != '0) && (cnt_q == lim)) || (&cnt_q);
   assign wrap   = tick & at_lim & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wrap,
   output ctrl_t             ctrl,
   output logic              clr,
   output logic [CNT_W-1:0]  lim
);
   localparam int unsigned HI_W = CNT_W - BUS_DW;

   logic [15:0]       cnt16, lim16;
   logic [BUS_DW-1:0] snap_q;
   logic              snap_v;
   logic              wr_ctrl;

   assign cnt16   = 16'(cnt);
   assign lim16   = 16'(lim);
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign clr     = wr_ctrl && bus_wdata[B_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.ie   <= 1'b0;
         ctrl.hold <= 1'b0;
         ctrl.sel  <= '0;
      end else if (wr_ctrl) begin
         ctrl.ie   <= bus_wdata[B_IE];
         ctrl.hold <= bus_wdata[B_HOLD];
         ctrl.sel  <= bus_wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctrl.flag <= 1'b0;
      else if (wrap)                         ctrl.flag <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_FLAG]) ctrl.flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim <= '0;
      else if (bus_wr && bus_addr == A_LIMH) lim[CNT_W-1:BUS_DW] <= bus_wdata[HI_W-1:0];
      else if (bus_wr && bus_addr == A_LIML) lim[BUS_DW-1:0]     <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         snap_v <= 1'b0;
      end else if (bus_rd && bus_addr == A_CNTH) begin
         snap_q <= cnt16[7:0];
         snap_v <= 1'b1;
      end else if (bus_rd && bus_addr == A_CNTL) begin
         snap_v <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {ctrl.flag, ctrl.ie, ctrl.hold, 2'b00, ctrl.sel};
         A_CNTH:  bus_rdata = cnt16[15:8];
         A_CNTL:  bus_rdata = snap_v ? snap_q : cnt16[7:0];
         A_LIMH:  bus_rdata = lim16[15:8];
         A_LIML:  bus_rdata = lim16[7:0];
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DIV_TAPS    = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              ext_clk,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              irq_o
);
   if (CNT_W <= BUS_DW || CNT_W > 2 * BUS_DW) begin : g_bad_w
      $error("tmr_timebase: CNT_W must lie in 9..16");
   end
   if (DIV_TAPS < 1 || DIV_TAPS > (1 << SEL_W) - 1) begin : g_bad_taps
      $error("tmr_timebase: DIV_TAPS must lie in 1..7");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_timebase: SYNC_STAGES must be at least 2");
   end

   ctrl_t            ctrl;
   logic             clr_pulse;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] lim_val;

   tmr_prescale #(.DIV_TAPS(DIV_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ctrl.sel),
      .run     (~ctrl.hold),
      .clr     (clr_pulse),
      .ext_clk (ext_clk),
      .tick    (tick)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (clr_pulse),
      .lim   (lim_val),
      .cnt_q (cnt_o),
      .wrap  (wrap)
   );

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt_o),
      .wrap      (wrap),
      .ctrl      (ctrl),
      .clr       (clr_pulse),
      .lim       (lim_val)
   );

   assign irq_o = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_o,
   input logic             flag,
   input logic             hold,
   input logic             clr,
   input logic [CNT_W-1:0] lim
);
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != $past(cnt_o)) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1) || cnt_o == '0)); // R2

   AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lim) != '0 && $past(cnt_o) == $past(lim) && cnt_o != $past(cnt_o)) |-> (cnt_o == '0)); // R4

   AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt_o == '0)); // R5

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> $stable(cnt_o)); // R8

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_o == '0)); // R9
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cnt_o (cnt_o),
   .flag  (ctrl.flag),
   .hold  (ctrl.hold),
   .clr   (clr_pulse),
   .lim   (lim_val)
);

// File: tb/sim_tmr_timebase.sv
`timescale 1ns/1ps
module sim_tmr_timebase;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_clk = 1'b0;
   logic [15:0] cnt_o;
   logic       irq_o;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   always #10 clk = ~clk;

   tmr_timebase u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_clk(ext_clk), .cnt_o(cnt_o), .irq_o(irq_o)
   );

   function automatic int unsigned ticks_of(int unsigned n, int unsigned code);
      return n >> code;
   endfunction

   function automatic int unsigned exp_cnt(int unsigned t, int unsigned lim);
      if (lim == 0) return t % 65536;
      return t % (lim + 1);
   endfunction

   function automatic bit exp_flag(int unsigned t, int unsigned lim);
      if (lim == 0) return t >= 65536;
      return t >= lim + 1;
   endfunction

   task automatic check(string req, int unsigned act, int unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d, hi, lo;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 count", cnt_o, 0);
      check("R1 irq", irq_o, 0);
      @(negedge clk);
      rd(3'd0, d); check("R1 ctrl", d, 8'h00);
      rd(3'd3, d); check("R1 limit hi", d, 8'h00);

      // R8, R9, R2: each internal divide code from a cleared, held start
      for (int c = 0; c < 7; c++) begin
         wr(3'd0, 8'h30 | 8'(c));
         check("R9 clear", cnt_o, 0);
         repeat (37) @(negedge clk);
         check("R8 hold", cnt_o, 0);
         rd(3'd0, d); check("R9 clr reads 0 / R8 hold bit", d, 8'h20 | 8'(c));
         wr(3'd1, 8'h55); wr(3'd2, 8'haa);
         check("R11 count write ignored", cnt_o, 0);
         wr(3'd0, 8'(c));
         repeat (200) @(negedge clk);
         check("R2 divide", cnt_o, ticks_of(200, c));
      end

      // R3: external clock
      wr(3'd0, 8'h37);
      wr(3'd0, 8'h07);
      ext_clk = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R3 latency 2", cnt_o, 0);
      @(negedge clk);
      check("R3 latency 3", cnt_o, 1);
      repeat (10) @(negedge clk);
      check("R3 level", cnt_o, 1);
      for (int p = 0; p < 4; p++) begin
         ext_clk = 1'b0; repeat (5) @(negedge clk);
         ext_clk = 1'b1; repeat (7) @(negedge clk);
      end
      ext_clk = 1'b0;
      check("R3 edges", cnt_o, 5);

      // R4, R6, R7, R12: random divide and limit
      for (int t = 0; t < 24; t++) begin
         int unsigned c, lim, n, e;
         c   = $urandom % 7;
         lim = ($urandom % 2) ? 0 : 1 + ($urandom % 300);
         if (t == 0) lim = 1;
         n   = 100 + ($urandom % 1900);
         wr(3'd0, 8'h30 | 8'(c));
         wr(3'd3, 8'(lim >> 8));
         wr(3'd4, 8'(lim));
         rd(3'd4, d); check("R12 limit lo", d, lim & 8'hff);
         rd(3'd3, d); check("R12 limit hi", d, lim >> 8);
         wr(3'd0, 8'h80 | 8'(c));
         repeat (n) @(negedge clk);
         e = exp_cnt(ticks_of(n, c), lim);
         check("R4 count", cnt_o, e);
         rd(3'd1, hi);
         rd(3'd2, lo);
         check("R6 coherent", {hi, lo}, e);
         rd(3'd2, lo);
         check("R6 live lo", lo, exp_cnt(ticks_of(n + 2, c), lim) & 8'hff);
         rd(3'd0, d);
         check("R4 flag", d, {exp_flag(ticks_of(n + 3, c), lim), 4'b0000, 3'(c)});
         check("R7 no disturb", cnt_o, exp_cnt(ticks_of(n + 4, c), lim));
      end

      // R5, R10: free-running wrap and interrupt
      wr(3'd0, 8'h30);
      wr(3'd3, 8'h00);
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h80);
      repeat (65541) @(negedge clk);
      check("R5 wrap count", cnt_o, 5);
      rd(3'd0, d); check("R5 flag", d, 8'h80);
      check("R10 irq masked", irq_o, 0);
      wr(3'd0, 8'h40);
      check("R10 irq raised", irq_o, 1);
      wr(3'd0, 8'hc0);
      check("R10 flag cleared", irq_o, 0);
      rd(3'd0, d); check("R10 ctrl", d, 8'h40);
      finish_run();
   end
endmodule